// File: doc/BRIEF.md
# Scaled Multiply-Accumulate Datapath

This block is the arithmetic core of a fixed-point signal-processing engine. A 16x16 multiplier takes one factor from a temporary register and the other from an input port, and writes a 32-bit product register. The ALU adds to, subtracts from, loads or logically combines a 32-bit accumulator with one of two operands. The first is the product register seen through a four-way scaler. The second is a 16-bit memory word shifted left by 0 to 16 places, with the upper bits filled from its sign or with zeros.

Overflow on add and subtract either wraps or clamps to the nearest 32-bit extreme, depending on a mode bit. A sticky overflow flag and a carry bit are kept. Carry follows a restricted rule for add and subtract with a 16-place operand shift, so that 32-bit values can be built from two 16-bit halves. Modes live in a small register loaded through `mode_wr`. Flags can be loaded together through `st_ld`, and the overflow flag can be cleared through `ov_clr`.

Top module: `sat_mac_dp`

## Requirements
- R1: One cycle after `mul_go`, `prod_o` holds the product of the temporary register and `mul_in`. The product is signed when `mul_signed`=1 and unsigned when it is 0. The temporary register loads `t_in` on `t_load`, and a multiply in the same cycle uses the old temporary value.
- R2: `prod_o` changes only on `mul_go`. Scaling the product on its way to the ALU never alters it.
- R3: With `src_prod`=1, the ALU operand is the product scaled by mode `pm`: 00 unchanged, 01 left 1, 10 left 4 (both zero-filled), 11 arithmetic right 6.
- R4: With `src_prod`=0, the operand is `mem_in` shifted left by a count, with the vacated low bits zero. The upper bits are a sign copy when `sxm`=1 and zero when `sxm`=0. The count is `shift_imm` when `cnt_from_t`=0 and the temporary register bits [3:0] when it is 1. An immediate above 16 acts as 16.
- R5: Opcodes: 0 no operation, 1 load accumulator, 2 add, 3 subtract, 4 AND, 5 OR, 6 XOR. Opcode 7 is treated as no operation.
- R6: With `ovm`=0, add and subtract wrap modulo 2^32. A signed overflow sets `ov_o`.
- R7: With `ovm`=1, a signed overflow on add or subtract clamps the accumulator. It becomes 0x7FFFFFFF when the old accumulator was non-negative and 0x80000000 otherwise.
- R8: `ov_o` is sticky. Once set, it stays set until `ov_clr` or `st_ld`; `st_ld` loads it from `st_ov`. An overflow in the same cycle as `ov_clr` leaves it set.
- R9: Outside the 16-place case, an add sets carry to its unsigned carry-out, and a subtract sets carry to 1 when no borrow occurs and 0 otherwise.
- R10: For add or subtract with a memory operand and an effective shift of 16, an add can only set carry and a subtract can only clear it.
- R11: No-operation, load, AND, OR and XOR leave carry and overflow unchanged. `st_ld` loads carry from `st_c` and takes priority over any ALU flag update.
- R12: After reset the accumulator and product are 0, carry is 1, overflow is 0, `sxm`=1, `pm`=00 and `ovm`=0. `mode_wr` loads `pm_in`, `sxm_in` and `ovm_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| t_load | input | 1 | Load temporary register |
| t_in | input | 16 | Temporary register data |
| mul_go | input | 1 | Write product register |
| mul_signed | input | 1 | 1: signed multiply |
| mul_in | input | 16 | Second multiplier factor |
| op | input | 3 | ALU opcode |
| src_prod | input | 1 | 1: scaled product operand, 0: shifted memory operand |
| mem_in | input | 16 | Memory operand |
| cnt_from_t | input | 1 | Shift count from temporary register bits [3:0] |
| shift_imm | input | 5 | Immediate shift count |
| mode_wr | input | 1 | Load mode register |
| pm_in | input | 2 | Product scale mode |
| sxm_in | input | 1 | Sign-extension mode |
| ovm_in | input | 1 | Saturation mode |
| ov_clr | input | 1 | Clear overflow flag |
| st_ld | input | 1 | Load both flags |
| st_ov | input | 1 | Overflow value for `st_ld` |
| st_c | input | 1 | Carry value for `st_ld` |
| acc_o | output | 32 | Accumulator |
| prod_o | output | 32 | Product register |
| ov_o | output | 1 | Sticky overflow flag |
| c_o | output | 1 | Carry |

## Verification
The assertions assume that all control inputs are known outside reset. They also assume that the 16-place carry case arises only from the immediate count, because a count taken from the temporary register cannot exceed 15. The random stimulus draws immediates from 0 to 16 and ties every control bit to a defined value each cycle. It pulses `st_ld` and `ov_clr` rarely, so that the sticky flag and the restricted carry rules are exercised across long runs of operations.

// File: rtl/sat_mac_dp.sv
module sat_mac_dp #(
  parameter int DW = 16,
  localparam int AW = 2 * DW,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          t_load,
  input  logic [DW-1:0] t_in,
  input  logic          mul_go,
  input  logic          mul_signed,
  input  logic [DW-1:0] mul_in,
  input  logic [2:0]    op,
  input  logic          src_prod,
  input  logic [DW-1:0] mem_in,
  input  logic          cnt_from_t,
  input  logic [CW-1:0] shift_imm,
  input  logic          mode_wr,
  input  logic [1:0]    pm_in,
  input  logic          sxm_in,
  input  logic          ovm_in,
  input  logic          ov_clr,
  input  logic          st_ld,
  input  logic          st_ov,
  input  logic          st_c,
  output logic [AW-1:0] acc_o,
  output logic [AW-1:0] prod_o,
  output logic          ov_o,
  output logic          c_o
);

  localparam logic [2:0] OP_LD  = 3'd1;
  localparam logic [2:0] OP_ADD = 3'd2;
  localparam logic [2:0] OP_SUB = 3'd3;
  localparam logic [2:0] OP_AND = 3'd4;
  localparam logic [2:0] OP_OR  = 3'd5;
  localparam logic [2:0] OP_XOR = 3'd6;

  logic [DW-1:0] t_q;
  logic [AW-1:0] acc_q, prod_q;
  logic          c_q, ov_q, sxm_q, ovm_q;
  logic [1:0]    pm_q;

  // multiplier
  logic [AW-1:0] mul_s, mul_u;
  assign mul_s = $signed(t_q) * $signed(mul_in);
  assign mul_u = t_q * mul_in;

  // product scaler
  logic [AW-1:0] prod_sc;
  always_comb begin
    case (pm_q)
      2'b01:   prod_sc = prod_q << 1;
      2'b10:   prod_sc = prod_q << 4;
      2'b11:   prod_sc = AW'($signed(prod_q) >>> 6);
      default: prod_sc = prod_q;
    endcase
  end

  // operand shifter
  logic [CW-1:0] cnt_raw, cnt;
  logic [AW-1:0] mem_ext, mem_sh;
  assign cnt_raw = cnt_from_t ? CW'(t_q[3:0]) : shift_imm;
  assign cnt     = (cnt_raw > CW'(DW)) ? CW'(DW) : cnt_raw;
  assign mem_ext = sxm_q ? {{DW{mem_in[DW-1]}}, mem_in} : {{DW{1'b0}}, mem_in};
  assign mem_sh  = mem_ext << cnt;

  logic [AW-1:0] opnd;
  logic          wide_shift;
  assign opnd       = src_prod ? prod_sc : mem_sh;
  assign wide_shift = !src_prod && (cnt == CW'(DW));

  // ALU
  logic [AW:0]   sum, dif;
  logic          is_add, is_sub, arith, alu_ov;
  logic [AW-1:0] arith_res, sat_val, acc_d;
  logic          c_arith;

  assign sum    = {1'b0, acc_q} + {1'b0, opnd};
  assign dif    = {1'b0, acc_q} - {1'b0, opnd};
  assign is_add = (op == OP_ADD);
  assign is_sub = (op == OP_SUB);
  assign arith  = is_add || is_sub;

  assign arith_res = is_add ? sum[AW-1:0] : dif[AW-1:0];
  assign alu_ov = arith &&
                  ((is_add ? (acc_q[AW-1] == opnd[AW-1]) : (acc_q[AW-1] != opnd[AW-1])) &&
                   (arith_res[AW-1] != acc_q[AW-1]));
  assign sat_val = acc_q[AW-1] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};

  always_comb begin
    if (is_add)
      c_arith = wide_shift ? (c_q | sum[AW]) : sum[AW];
    else
      c_arith = wide_shift ? (c_q & ~dif[AW]) : ~dif[AW];
  end

  always_comb begin
    case (op)
      OP_LD:          acc_d = opnd;
      OP_ADD, OP_SUB: acc_d = (alu_ov && ovm_q) ? sat_val : arith_res;
      OP_AND:         acc_d = acc_q & opnd;
      OP_OR:          acc_d = acc_q | opnd;
      OP_XOR:         acc_d = acc_q ^ opnd;
      default:        acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q    <= '0;
      prod_q <= '0;
      acc_q  <= '0;
      c_q    <= 1'b1;
      ov_q   <= 1'b0;
      sxm_q  <= 1'b1;
      pm_q   <= 2'b00;
      ovm_q  <= 1'b0;
    end else begin
      if (t_load) t_q <= t_in;
      if (mul_go) prod_q <= mul_signed ? mul_s : mul_u;
      if (mode_wr) begin
        pm_q  <= pm_in;
        sxm_q <= sxm_in;
        ovm_q <= ovm_in;
      end
      acc_q <= acc_d;
      if (st_ld) begin
        c_q  <= st_c;
        ov_q <= st_ov;
      end else begin
        if (arith) c_q <= c_arith;
        ov_q <= (ov_q & ~ov_clr) | alu_ov;
      end
    end
  end

  assign acc_o  = acc_q;
  assign prod_o = prod_q;
  assign ov_o   = ov_q;
  assign c_o    = c_q;

  // R2: product register held unless a multiply is requested
  a_r2_prod_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mul_go |=> $stable(prod_o));

  // R8: overflow flag sticky
  a_r8_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_o && !ov_clr && !st_ld) |=> ov_o);

  // R10: wide-shift add never clears carry
  a_r10_add_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    (is_add && wide_shift && c_o && !st_ld) |=> c_o);

  // R10: wide-shift subtract never sets carry
  a_r10_sub_keeps_nc: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sub && wide_shift && !c_o && !st_ld) |=> !c_o);

  // R11: non-arithmetic ops leave flags alone
  a_r11_flags_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!arith && !st_ld && !ov_clr) |=> ($stable(c_o) && $stable(ov_o)));

  // R7: saturated result never wraps past the extreme in the wrong direction
  a_r7_sat_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_ov && ovm_q) |=> (acc_o[AW-1] == $past(acc_o[AW-1])));

endmodule

// File: tb/sat_mac_dp_tb.sv
module sat_mac_dp_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic t_load = 0, mul_go = 0, mul_signed = 0, src_prod = 0, cnt_from_t = 0;
  logic mode_wr = 0, sxm_in = 0, ovm_in = 0, ov_clr = 0, st_ld = 0, st_ov = 0, st_c = 0;
  logic [15:0] t_in = 0, mul_in = 0, mem_in = 0;
  logic [2:0] op = 0;
  logic [4:0] shift_imm = 0;
  logic [1:0] pm_in = 0;
  logic [31:0] acc_o, prod_o;
  logic ov_o, c_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [15:0] m_t;
  logic [31:0] m_acc, m_prod;
  logic m_c, m_ov, m_sxm, m_ovm;
  logic [1:0] m_pm;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_mac_dp dut_i (.clk, .rst_n, .t_load, .t_in, .mul_go, .mul_signed, .mul_in,
    .op, .src_prod, .mem_in, .cnt_from_t, .shift_imm, .mode_wr, .pm_in, .sxm_in,
    .ovm_in, .ov_clr, .st_ld, .st_ov, .st_c, .acc_o, .prod_o, .ov_o, .c_o);

  function automatic logic [31:0] scale_prod(logic [31:0] p, logic [1:0] m);
    longint s = longint'($signed(p));
    case (m)
      2'd1: return 32'(p * 2);
      2'd2: return 32'(p * 16);
      2'd3: return 32'((s - ((s % 64 + 64) % 64)) / 64);
      default: return p;
    endcase
  endfunction

  function automatic logic [31:0] shift_mem(logic [15:0] w, int n, logic sx);
    longint v = sx ? longint'($signed(w)) : longint'(w);
    return 32'(v * (longint'(1) << n));
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(string tag);
    checks++;
    if (acc_o !== m_acc || prod_o !== m_prod || ov_o !== m_ov || c_o !== m_c) begin
      errors++;
      $display("FAIL %s: acc=%h prod=%h ov=%b c=%b expected acc=%h prod=%h ov=%b c=%b",
               tag, acc_o, prod_o, ov_o, c_o, m_acc, m_prod, m_ov, m_c);
    end
  endtask

  // apply one clock with current inputs, update model, compare
  task automatic step(string tag);
    int n;
    logic [31:0] b, res;
    longint sa, sb, sr;
    logic carry, borrow, ovf, wide;
    n = cnt_from_t ? int'(m_t[3:0]) : ((shift_imm > 16) ? 16 : int'(shift_imm));
    b = src_prod ? scale_prod(m_prod, m_pm) : shift_mem(mem_in, n, m_sxm);
    wide = !src_prod && n == 16;
    sa = longint'($signed(m_acc)); sb = longint'($signed(b));
    sr = (op == 3'd2) ? sa + sb : sa - sb;
    ovf = (op == 3'd2 || op == 3'd3) && (sr > 64'sd2147483647 || sr < -64'sd2147483648);
    carry  = (longint'(m_acc) + longint'(b)) > 64'hFFFFFFFF;
    borrow = m_acc < b;
    @(posedge clk);
    case (op)
      3'd1: m_acc = b;
      3'd2, 3'd3: begin
        res = 32'(sr);
        m_acc = (ovf && m_ovm) ? (m_acc[31] ? 32'h80000000 : 32'h7FFFFFFF) : res;
      end
      3'd4: m_acc = m_acc & b;
      3'd5: m_acc = m_acc | b;
      3'd6: m_acc = m_acc ^ b;
      default: ;
    endcase
    if (st_ld) begin m_c = st_c; m_ov = st_ov; end
    else begin
      if (op == 3'd2) m_c = wide ? (m_c | carry) : carry;
      if (op == 3'd3) m_c = wide ? (m_c & !borrow) : !borrow;
      m_ov = (m_ov & !ov_clr) | ovf;
    end
    if (mul_go) m_prod = mul_signed ? 32'($signed(m_t) * $signed(mul_in)) : 32'(m_t) * 32'(mul_in);
    if (t_load) m_t = t_in;
    if (mode_wr) begin m_pm = pm_in; m_sxm = sxm_in; m_ovm = ovm_in; end
    #1;
    check(tag);
  endtask

  task automatic idle();
    t_load = 0; mul_go = 0; op = 0; src_prod = 0; cnt_from_t = 0; shift_imm = 0;
    mode_wr = 0; ov_clr = 0; st_ld = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    m_t = 0; m_acc = 0; m_prod = 0; m_c = 1; m_ov = 0; m_sxm = 1; m_ovm = 0; m_pm = 0;
    repeat (3) @(posedge clk);
    #1; check("R12 reset values");
    @(negedge clk); rst_n = 1;

    // R12/R4: sign extension active after reset
    @(negedge clk); idle(); op = 3'd1; mem_in = 16'h8000; step("R12 R4 sign fill after reset");
    // R4: shift by 16 with sign
    @(negedge clk); idle(); op = 3'd1; mem_in = 16'hABCD; shift_imm = 16; step("R4 shift 16");
    // R4: zero fill
    @(negedge clk); idle(); mode_wr = 1; sxm_in = 0; pm_in = 0; ovm_in = 0; step("R12 mode write");
    @(negedge clk); idle(); op = 3'd1; mem_in = 16'hF00F; shift_imm = 4; step("R4 zero fill");
    // R4: count from temporary register
    @(negedge clk); idle(); t_load = 1; t_in = 16'h0007; step("R1 t load");
    @(negedge clk); idle(); op = 3'd1; mem_in = 16'h0003; cnt_from_t = 1; step("R4 count from t");
    // R1: unsigned and signed full-scale multiply
    @(negedge clk); idle(); t_load = 1; t_in = 16'hFFFF; step("R1 t load");
    @(negedge clk); idle(); mul_go = 1; mul_in = 16'hFFFF; mul_signed = 0; step("R1 unsigned mult");
    @(negedge clk); idle(); mul_go = 1; mul_signed = 1; step("R1 signed mult");
    // R1: same-cycle t_load uses old T
    @(negedge clk); idle(); mul_go = 1; mul_signed = 1; mul_in = 16'h0003; t_load = 1; t_in = 16'h0100; step("R1 old T used");
    // R3: product scaling, each mode
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); idle(); mode_wr = 1; pm_in = 2'(m); sxm_in = 1; ovm_in = 0; step("R3 mode");
      @(negedge clk); idle(); op = 3'd1; src_prod = 1; step("R3 R2 scaled load");
    end
    @(negedge clk); idle(); mul_go = 1; mul_signed = 1; mul_in = 16'h8000; step("R1 negative product");
    @(negedge clk); idle(); op = 3'd1; src_prod = 1; step("R3 arith right 6 negative");
    // R6: wrap at positive extreme
    @(negedge clk); idle(); mode_wr = 1; pm_in = 0; sxm_in = 0; ovm_in = 0; step("R12 mode");
    @(negedge clk); idle(); op = 3'd1; mem_in = 16'h7FFF; shift_imm = 16; step("R5 load");
    @(negedge clk); idle(); op = 3'd5; mem_in = 16'hFFFF; step("R5 OR R11");
    @(negedge clk); idle(); op = 3'd2; mem_in = 16'h0001; step("R6 wrap add overflow");
    @(negedge clk); idle(); op = 3'd4; mem_in = 16'h1234; step("R8 R11 sticky through AND");
    @(negedge clk); idle(); ov_clr = 1; step("R8 clear");
    // R7: saturation
    @(negedge clk); idle(); mode_wr = 1; ovm_in = 1; step("R12 mode");
    @(negedge clk); idle(); op = 3'd1; mem_in = 16'h7FFF; shift_imm = 16; step("R5 load");
    @(negedge clk); idle(); op = 3'd2; mem_in = 16'h4000; shift_imm = 16; step("R7 R10 saturate positive");
    @(negedge clk); idle(); st_ld = 1; st_ov = 0; st_c = 0; step("R8 R11 status load");
    @(negedge clk); idle(); op = 3'd1; mem_in = 16'h8000; shift_imm = 16; step("R5 load");
    @(negedge clk); idle(); op = 3'd3; mem_in = 16'h0001; step("R7 R9 saturate negative");
    @(negedge clk); idle(); op = 3'd3; mem_in = 16'h0001; shift_imm = 16; ov_clr = 1; step("R10 R8 wide sub and clear");
    @(negedge clk); idle(); op = 3'd7; step("R5 opcode 7 noop");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      t_load = ($urandom % 4) == 0; t_in = 16'($urandom);
      mul_go = ($urandom % 3) == 0; mul_signed = 1'($urandom); mul_in = 16'($urandom);
      op = 3'($urandom); src_prod = 1'($urandom); mem_in = 16'($urandom);
      cnt_from_t = ($urandom % 4) == 0;
      shift_imm = ($urandom % 3 == 0) ? 5'd16 : 5'($urandom % 17);
      mode_wr = ($urandom % 16) == 0; pm_in = 2'($urandom); sxm_in = 1'($urandom); ovm_in = 1'($urandom);
      ov_clr = ($urandom % 32) == 0; st_ld = ($urandom % 64) == 0; st_ov = 1'($urandom); st_c = 1'($urandom);
      if (op == 3'd2 || op == 3'd3) step("R6 R7 R9 R10 random arith");
      else step("R1 R2 R3 R4 R5 R11 random");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule